// File: doc/BRIEF.md
# Edge-Triggered External Interrupt and Wakeup Controller

This block collects a set of external signal lines and turns their transitions into a single interrupt request, a single event pulse and one wakeup flag per line. The first sixteen lines are each fed from a selectable port. Each of these lines takes the same-numbered pin of whichever port its 4-bit select field names. The remaining lines come straight from dedicated inputs. The low-numbered lines are configurable: each has its own rising and falling trigger enables and a sticky pending bit. The highest-numbered lines are direct: they act on the input level and keep no pending state.

Software drives the block through a simple word-addressed register bus. Writes take effect on the next clock edge, and reads are combinational from the address. Through the bus, software sets the trigger, interrupt-mask and event-mask enables. It clears pending bits by writing ones, and it raises pending bits by writing to the software-trigger register. It also chooses, for every line, how the wakeup flag is released. The flag can drop by itself a fixed number of cycles after the trigger, or it can wait for a pulse on one of four external clear inputs. Before edge detection, every input passes through a two-stage synchronizer.

Top module: `xirq_ctrl`

## Requirements
- R1: A configurable line (index below N_CFG) sets its pending bit on a rising edge when its bit in RISE (address 2) is set, and on a falling edge when its bit in FALL (address 3) is set. With both bits set, either edge sets the pending bit. With neither set, no edge does.
- R2: A pending bit (PEND, address 4) stays set until a write of one to that bit position. Zero bits in a PEND write leave the pending state unchanged.
- R3: If a trigger edge and a PEND write of one hit the same line in the same cycle, the pending bit ends up set.
- R4: Writing one to a configurable line's bit of SWTRG (address 5) sets that line's pending bit on the write cycle. SWTRG reads as zero, and writing it has no effect on direct lines.
- R5: irq_o is high whenever some line with its IMASK bit (address 0) set has its pending bit set, or is a direct line whose synchronized input is high. It is low when no such line exists.
- R6: evt_o pulses high for exactly one cycle for each trigger on a line whose EMASK bit (address 1) is set. This pulse does not depend on IMASK, and nothing about it is latched.
- R7: Line k below 16 takes pin k of the port selected by its 4-bit field. That field is at bits [4*(k%4)+3 : 4*(k%4)] of the register at address 9 + k/4. Pins of ports that are not selected have no effect on the line.
- R8: A configurable line whose PCMODE bit (address 6) is 0 raises wake_o for exactly WAKE_DLY cycles after a trigger.
- R9: On a direct line whose PCMODE bit is 0, wake_o follows the synchronized input. A direct line never shows a pending bit.
- R10: When a line's PCMODE bit is 1, the line's wake_o is set by a trigger and held until a pulse on clr_pulse_i[src]. Here src is the 2-bit field at bits [2k+1:2k] of CSRC_LO (address 7) for lines k below 16, and at bits [2(k-16)+1 : 2(k-16)] of CSRC_HI (address 8) for lines 16 and up. Pulses on any other clear input are ignored.
- R11: After reset, all registers read zero and irq_o, evt_o and wake_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| port_pins_i | input | N_PORTS*MUX_LINES (64) | Port pins, port p pin k at bit p*MUX_LINES+k |
| ext_lines_i | input | N_LINES-MUX_LINES (8) | Inputs for lines MUX_LINES and up |
| clr_pulse_i | input | 4 | External wakeup clear pulses |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | 1 | Combined event pulse |
| wake_o | output | N_LINES (24) | Per-line wakeup flags |

## Verification
The bench aims a trigger edge at the very cycle in which a clearing write lands. A design that lets the clear win would lose that interrupt. Pins are toggled on a port that is not selected, which would set a pending bit if the port select were decoded wrongly. Falling-only and both-edge setups are checked, and a randomized run covers every configurable line with each trigger polarity. The bench counts wakeup high cycles against the delay and fires clear pulses from both the right and the wrong source. A misplaced clear-source field, or one read from the wrong register half, then either leaves the flag stuck or drops it early. The bench also counts event pulses: a latched or stretched event shows up as more than one high cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 4;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned CSRC_W = 2;
  localparam int unsigned N_CLR  = 4;

  typedef enum logic [AW-1:0] {
    A_IMASK   = 4'd0,
    A_EMASK   = 4'd1,
    A_RISE    = 4'd2,
    A_FALL    = 4'd3,
    A_PEND    = 4'd4,
    A_SWTRG   = 4'd5,
    A_PCMODE  = 4'd6,
    A_CSRC_LO = 4'd7,
    A_CSRC_HI = 4'd8,
    A_PSEL0   = 4'd9,
    A_PSEL1   = 4'd10,
    A_PSEL2   = 4'd11,
    A_PSEL3   = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/xirq_line.sv
module xirq_line #(
  parameter bit          IS_CFG   = 1'b1,
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic sw_i,
  input  logic w1c_i,
  input  logic pcmode_i,
  input  logic clr_hit_i,
  output logic trig_o,
  output logic level_o,
  output logic pend_o,
  output logic wake_o
);
  logic s1_q, s2_q, prev_q;
  logic rise_edge, fall_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_edge = s2_q & ~prev_q;
  assign fall_edge = ~s2_q & prev_q;
  assign level_o   = s2_q;

  if (IS_CFG) begin : g_cfg
    localparam int unsigned CW = $clog2(WAKE_DLY + 1);
    logic          pend_q, wake_q;
    logic [CW-1:0] cnt_q;

    assign trig_o = (rise_edge & rise_en_i) | (fall_edge & fall_en_i) | sw_i;

    // a new trigger wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q <= 1'b0;
      else if (trig_o)  pend_q <= 1'b1;
      else if (w1c_i)   pend_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wake_q <= 1'b0;
        cnt_q  <= '0;
      end else if (trig_o) begin
        wake_q <= 1'b1;
        cnt_q  <= CW'(WAKE_DLY);
      end else if (pcmode_i) begin
        if (clr_hit_i) wake_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) wake_q <= 1'b0;
      end
    end

    assign pend_o = pend_q;
    assign wake_o = wake_q;
  end else begin : g_dir
    logic wake_q;
    logic unused_dir;
    assign unused_dir = ^{rise_en_i, fall_en_i, sw_i, w1c_i};
    assign trig_o = rise_edge;
    assign pend_o = 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             wake_q <= 1'b0;
      else if (!pcmode_i)      wake_q <= s2_q;
      else if (rise_edge)      wake_q <= 1'b1;
      else if (clr_hit_i)      wake_q <= 1'b0;
    end

    assign wake_o = wake_q;
  end
endmodule

// File: rtl/xirq_src_mux.sv
module xirq_src_mux
  import xirq_pkg::*;
#(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned MUX_LINES = 16
) (
  input  logic [N_PORTS*MUX_LINES-1:0] port_pins_i,
  input  logic [SEL_W*MUX_LINES-1:0]   psel_i,
  output logic [MUX_LINES-1:0]         line_o
);
  for (genvar k = 0; k < MUX_LINES; k++) begin : g_ln
    logic pick;
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < int'(N_PORTS); p++)
        if (psel_i[SEL_W*k +: SEL_W] == SEL_W'(p)) pick = port_pins_i[p*MUX_LINES + k];
    end
    assign line_o[k] = pick;
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned N_LINES   = 24,
  parameter int unsigned N_CFG     = 20,
  parameter int unsigned MUX_LINES = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sel_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  input  logic [N_LINES-1:0]          pend_i,
  output logic [N_LINES-1:0]          imask_o,
  output logic [N_LINES-1:0]          emask_o,
  output logic [N_LINES-1:0]          rise_o,
  output logic [N_LINES-1:0]          fall_o,
  output logic [N_LINES-1:0]          pcmode_o,
  output logic [CSRC_W*N_LINES-1:0]   csrc_o,
  output logic [SEL_W*MUX_LINES-1:0]  psel_o,
  output logic [N_LINES-1:0]          w1c_o,
  output logic [N_LINES-1:0]          sw_o
);
  localparam logic [N_LINES-1:0] CFG_MASK = N_LINES'((64'd1 << N_CFG) - 64'd1);
  localparam int unsigned HALF = DW / CSRC_W;

  logic                       wr;
  logic [N_LINES-1:0]         imask_q, emask_q, rise_q, fall_q, pcmode_q;
  logic [CSRC_W*N_LINES-1:0]  csrc_q;
  logic [SEL_W*MUX_LINES-1:0] psel_q;
  logic [N_LINES-1:0]         wd;

  assign wr = sel_i & we_i;
  assign wd = wdata_i[N_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q  <= '0;
      emask_q  <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      pcmode_q <= '0;
    end else if (wr) begin
      case (addr_i)
        A_IMASK:  imask_q  <= wd;
        A_EMASK:  emask_q  <= wd;
        A_RISE:   rise_q   <= wd & CFG_MASK;
        A_FALL:   fall_q   <= wd & CFG_MASK;
        A_PCMODE: pcmode_q <= wd;
        default: ;
      endcase
    end
  end

  // clear-source fields: low half lines in one word, high half in the next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csrc_q <= '0;
    else if (wr) begin
      for (int k = 0; k < int'(N_LINES); k++) begin
        if ((k < int'(HALF)) && (addr_i == A_CSRC_LO))
          csrc_q[CSRC_W*k +: CSRC_W] <= wdata_i[(CSRC_W*k) % DW +: CSRC_W];
        if ((k >= int'(HALF)) && (addr_i == A_CSRC_HI))
          csrc_q[CSRC_W*k +: CSRC_W] <= wdata_i[(CSRC_W*k) % DW +: CSRC_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psel_q <= '0;
    else if (wr) begin
      for (int i = 0; i < int'(MUX_LINES); i++)
        if (addr_i == AW'(int'(A_PSEL0) + i / 4))
          psel_q[SEL_W*i +: SEL_W] <= wdata_i[SEL_W*(i % 4) +: SEL_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IMASK:  rdata_o[N_LINES-1:0] = imask_q;
      A_EMASK:  rdata_o[N_LINES-1:0] = emask_q;
      A_RISE:   rdata_o[N_LINES-1:0] = rise_q;
      A_FALL:   rdata_o[N_LINES-1:0] = fall_q;
      A_PEND:   rdata_o[N_LINES-1:0] = pend_i;
      A_PCMODE: rdata_o[N_LINES-1:0] = pcmode_q;
      default: ;
    endcase
    for (int k = 0; k < int'(N_LINES); k++) begin
      if ((k < int'(HALF)) && (addr_i == A_CSRC_LO))
        rdata_o[(CSRC_W*k) % DW +: CSRC_W] = csrc_q[CSRC_W*k +: CSRC_W];
      if ((k >= int'(HALF)) && (addr_i == A_CSRC_HI))
        rdata_o[(CSRC_W*k) % DW +: CSRC_W] = csrc_q[CSRC_W*k +: CSRC_W];
    end
    for (int i = 0; i < int'(MUX_LINES); i++)
      if (addr_i == AW'(int'(A_PSEL0) + i / 4))
        rdata_o[SEL_W*(i % 4) +: SEL_W] = psel_q[SEL_W*i +: SEL_W];
  end

  assign w1c_o    = (wr && addr_i == A_PEND)  ? wd : '0;
  assign sw_o     = (wr && addr_i == A_SWTRG) ? (wd & CFG_MASK) : '0;
  assign imask_o  = imask_q;
  assign emask_o  = emask_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign pcmode_o = pcmode_q;
  assign csrc_o   = csrc_q;
  assign psel_o   = psel_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned N_LINES   = 24,
  parameter int unsigned N_CFG     = 20,
  parameter int unsigned MUX_LINES = 16,
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned WAKE_DLY  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_sel_i,
  input  logic                         bus_we_i,
  input  logic [AW-1:0]                bus_addr_i,
  input  logic [DW-1:0]                bus_wdata_i,
  output logic [DW-1:0]                bus_rdata_o,
  input  logic [N_PORTS*MUX_LINES-1:0] port_pins_i,
  input  logic [N_LINES-MUX_LINES-1:0] ext_lines_i,
  input  logic [N_CLR-1:0]             clr_pulse_i,
  output logic                         irq_o,
  output logic                         evt_o,
  output logic [N_LINES-1:0]           wake_o
);
  localparam logic [N_LINES-1:0] CFG_MASK = N_LINES'((64'd1 << N_CFG) - 64'd1);

  logic [N_LINES-1:0]         imask_q, emask_q, rise_q, fall_q, pcmode_q;
  logic [CSRC_W*N_LINES-1:0]  csrc_q;
  logic [SEL_W*MUX_LINES-1:0] psel_q;
  logic [N_LINES-1:0]         w1c_vec, sw_vec, trig_vec, level_vec, pend_vec, clr_hit_vec;
  logic [MUX_LINES-1:0]       mux_lines;
  logic [N_LINES-1:0]         raw_lines;

  xirq_regs #(.N_LINES(N_LINES), .N_CFG(N_CFG), .MUX_LINES(MUX_LINES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .pend_i   (pend_vec),
    .imask_o  (imask_q),
    .emask_o  (emask_q),
    .rise_o   (rise_q),
    .fall_o   (fall_q),
    .pcmode_o (pcmode_q),
    .csrc_o   (csrc_q),
    .psel_o   (psel_q),
    .w1c_o    (w1c_vec),
    .sw_o     (sw_vec)
  );

  xirq_src_mux #(.N_PORTS(N_PORTS), .MUX_LINES(MUX_LINES)) u_mux (
    .port_pins_i (port_pins_i),
    .psel_i      (psel_q),
    .line_o      (mux_lines)
  );

  assign raw_lines = {ext_lines_i, mux_lines};

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    assign clr_hit_vec[l] = pcmode_q[l] & clr_pulse_i[csrc_q[CSRC_W*l +: CSRC_W]];

    xirq_line #(.IS_CFG(l < N_CFG), .WAKE_DLY(WAKE_DLY)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (raw_lines[l]),
      .rise_en_i (rise_q[l]),
      .fall_en_i (fall_q[l]),
      .sw_i      (sw_vec[l]),
      .w1c_i     (w1c_vec[l]),
      .pcmode_i  (pcmode_q[l]),
      .clr_hit_i (clr_hit_vec[l]),
      .trig_o    (trig_vec[l]),
      .level_o   (level_vec[l]),
      .pend_o    (pend_vec[l]),
      .wake_o    (wake_o[l])
    );
  end

  // direct lines drive the request by level, configurable ones by pending state
  assign irq_o = |((pend_vec | (level_vec & ~CFG_MASK)) & imask_q);
  assign evt_o = |(trig_vec & emask_q);
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
  parameter int unsigned N_LINES = 24,
  parameter int unsigned N_CFG   = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic               evt_o,
  input logic [N_LINES-1:0] wake_o,
  input logic [N_LINES-1:0] pend_vec,
  input logic [N_LINES-1:0] w1c_vec,
  input logic [N_LINES-1:0] trig_vec,
  input logic [N_LINES-1:0] sw_vec,
  input logic [N_LINES-1:0] imask_q,
  input logic [N_LINES-1:0] pcmode_q,
  input logic [N_LINES-1:0] clr_hit_vec
);
  localparam logic [N_LINES-1:0] CFG_MASK = N_LINES'((64'd1 << N_CFG) - 64'd1);

  assert_pend_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_vec) & ~$past(w1c_vec) & ~pend_vec) == '0));

  assert_edge_beats_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(trig_vec & w1c_vec) & CFG_MASK & ~pend_vec) == '0));

  assert_sw_sets_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sw_vec) & CFG_MASK & ~pend_vec) == '0));

  assert_irq_on_masked_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_vec & imask_q)) |-> irq_o);

  assert_wake_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(wake_o & pcmode_q & ~clr_hit_vec) & ~wake_o) == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R11: assert (!irq_o && !evt_o && wake_o == '0);
    end
  end
endmodule

bind xirq_ctrl xirq_checker #(.N_LINES(N_LINES), .N_CFG(N_CFG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .evt_o       (evt_o),
  .wake_o      (wake_o),
  .pend_vec    (pend_vec),
  .w1c_vec     (w1c_vec),
  .trig_vec    (trig_vec),
  .sw_vec      (sw_vec),
  .imask_q     (imask_q),
  .pcmode_q    (pcmode_q),
  .clr_hit_vec (clr_hit_vec)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  import xirq_pkg::*;
  localparam int NL = 24, NC = 20, ML = 16, NP = 4, WD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bsel = 1'b0, bwe = 1'b0;
  logic [3:0] baddr = '0;
  logic [31:0] bwdata = '0, brdata;
  logic [NP*ML-1:0] pins = '0;
  logic [NL-ML-1:0] ext = '0;
  logic [3:0] clrp = '0;
  logic irq, evt;
  logic [NL-1:0] wake;

  int total = 0, bad = 0;
  logic lvl [NL];
  int psel_m [ML];

  xirq_ctrl u_xirq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bsel), .bus_we_i(bwe), .bus_addr_i(baddr),
    .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .port_pins_i(pins), .ext_lines_i(ext),
    .clr_pulse_i(clrp), .irq_o(irq), .evt_o(evt), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bsel = 1'b1; bwe = 1'b1; baddr = a; bwdata = d;
    @(posedge clk); @(negedge clk);
    bsel = 1'b0; bwe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    baddr = a; #1; d = brdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input int l, input logic v);
    if (l < ML) pins[psel_m[l]*ML + l] = v;
    else ext[l-ML] = v;
    lvl[l] = v;
  endtask

  function automatic logic [31:0] bit_of(input int l);
    return 32'd1 << l;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) lvl[i] = 1'b0;
    for (int i = 0; i < ML; i++) psel_m[i] = 0;
    repeat (3) @(negedge clk);
    chk(!irq && !evt && wake == '0, "R11", "outputs in reset", {irq, evt, wake}, 0);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a <= 12; a++) begin
      rd(4'(a), v);
      chk(v == 0, "R11", "register after reset", v, 0);
    end

    // port select: line 5 from port 2 (field bits [7:4] at address 10)
    wr(A_PSEL1, 32'h2 << 4); psel_m[5] = 2;
    wr(A_RISE, bit_of(5));
    pins[0*ML + 5] = 1'b1;
    idle(6); rd(A_PEND, v);
    chk(v == 0, "R7", "unselected port pin", v, 0);
    set_line(5, 1'b1);
    idle(6); rd(A_PEND, v);
    chk(v == bit_of(5), "R1", "rising on selected port", v, bit_of(5));
    wr(A_PEND, 32'h0); rd(A_PEND, v);
    chk(v == bit_of(5), "R2", "zero write keeps pending", v, bit_of(5));
    set_line(5, 1'b0); idle(6);
    wr(A_IMASK, bit_of(5)); idle(1);
    chk(irq == 1'b1, "R5", "irq with masked pending", irq, 1);
    wr(A_PEND, bit_of(5)); rd(A_PEND, v);
    chk(v == 0, "R2", "w1c clears", v, 0);
    chk(irq == 1'b0, "R5", "irq drops after clear", irq, 0);

    // software trigger
    wr(A_SWTRG, bit_of(5)); rd(A_PEND, v);
    chk(v == bit_of(5), "R4", "sw trigger sets pending", v, bit_of(5));
    rd(A_SWTRG, v);
    chk(v == 0, "R4", "swtrg reads zero", v, 0);

    // edge and clear in the same cycle
    set_line(5, 1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    bsel = 1'b1; bwe = 1'b1; baddr = A_PEND; bwdata = bit_of(5);
    @(posedge clk); @(negedge clk);
    bsel = 1'b0; bwe = 1'b0;
    rd(A_PEND, v);
    chk(v == bit_of(5), "R3", "edge beats clear", v, bit_of(5));
    wr(A_PEND, bit_of(5)); wr(A_IMASK, 0);
    wr(A_SWTRG, bit_of(21)); rd(A_PEND, v);
    chk(v == 0, "R4", "sw trigger ignored on direct line", v, 0);

    // event pulse, both edges on line 6
    wr(A_EMASK, bit_of(6)); wr(A_RISE, bit_of(6)); wr(A_FALL, bit_of(6));
    set_line(6, 1'b1); n = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (evt) n++; end
    chk(n == 1, "R6", "event pulse on rise", n, 1);
    chk(irq == 1'b0, "R6", "event independent of irq mask", irq, 0);
    set_line(6, 1'b0); n = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (evt) n++; end
    chk(n == 1, "R6", "event pulse on fall", n, 1);
    wr(A_EMASK, 0); wr(A_PEND, 32'hFFFFFF);

    // falling only on line 7
    wr(A_RISE, 0); wr(A_FALL, bit_of(7));
    set_line(7, 1'b1); idle(6); rd(A_PEND, v);
    chk(v == 0, "R1", "rise ignored with fall-only", v, 0);
    set_line(7, 1'b0); idle(6); rd(A_PEND, v);
    chk(v == bit_of(7), "R1", "fall-only detects fall", v, bit_of(7));
    wr(A_PEND, 32'hFFFFFF); wr(A_FALL, 0);

    // automatic wake clear
    idle(10);
    wr(A_RISE, bit_of(8));
    set_line(8, 1'b1); n = 0;
    for (int c = 0; c < 15; c++) begin @(negedge clk); if (wake[8]) n++; end
    chk(n == WD, "R8", "auto wake length", n, WD);

    // direct line 21 (ext bit 5)
    wr(A_IMASK, bit_of(21));
    set_line(21, 1'b1); idle(5);
    chk(wake[21] == 1'b1, "R9", "direct wake follows high", wake[21], 1);
    chk(irq == 1'b1, "R5", "direct line level irq", irq, 1);
    rd(A_PEND, v);
    chk(v[21] == 1'b0, "R9", "direct line no pending", v[21], 0);
    set_line(21, 1'b0); idle(5);
    chk(wake[21] == 1'b0 && irq == 1'b0, "R9", "direct wake follows low", {wake[21], irq}, 0);
    wr(A_IMASK, 0);

    // selectable clear source: line 9 src 2 (LO bits [19:18]), line 18 src 3 (HI bits [5:4])
    wr(A_PCMODE, bit_of(9) | bit_of(18));
    wr(A_CSRC_LO, 32'h2 << 18); wr(A_CSRC_HI, 32'h3 << 4);
    rd(A_CSRC_HI, v);
    chk(v == (32'h3 << 4), "R10", "csrc high readback", v, 32'h3 << 4);
    wr(A_RISE, bit_of(9) | bit_of(18));
    set_line(9, 1'b1); set_line(18, 1'b1); idle(15);
    chk(wake[9] && wake[18], "R10", "wake held past delay", {wake[9], wake[18]}, 3);
    clrp = 4'b0010; idle(1); clrp = 4'b0000; idle(1);
    chk(wake[9] == 1'b1, "R10", "wrong source ignored", wake[9], 1);
    clrp = 4'b0100; idle(1); clrp = 4'b0000;
    chk(wake[9] == 1'b0 && wake[18] == 1'b1, "R10", "source 2 clears line 9 only", {wake[9], wake[18]}, 1);
    clrp = 4'b1000; idle(1); clrp = 4'b0000;
    chk(wake[18] == 1'b0, "R10", "source 3 clears line 18", wake[18], 0);
    wr(A_PCMODE, 0);

    // randomized polarity coverage on configurable lines
    for (int it = 0; it < 40; it++) begin
      int l;
      bit r, f;
      logic nv;
      logic [31:0] ex;
      l = $urandom_range(NC-1, 0);
      r = 1'($urandom_range(1, 0));
      f = 1'($urandom_range(1, 0));
      wr(A_RISE, 32'(r) << l);
      wr(A_FALL, 32'(f) << l);
      wr(A_PEND, 32'hFFFFFF);
      nv = ~lvl[l];
      set_line(l, nv);
      idle(6);
      rd(A_PEND, v);
      ex = ((nv && r) || (!nv && f)) ? bit_of(l) : 32'd0;
      chk(v == ex, "R1", "random edge pending", v, ex);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule